// File: doc/BRIEF.md
# Privileged Return and Hardware-Register Read Gate

This block decides the outcome of a few privileged operations for a coprocessor-0 style control unit. It handles a return from an exception, a return from debug mode, the interrupt-disable and interrupt-enable operations, and a guarded read of four hardware values. It takes the live status word, the three saved return addresses, the debug-mode flag, a kernel-access flag, a per-register enable mask, the exception base word and the counter values. It produces the next PC, the next status word, the read data and a reserved-instruction exception flag.

All decisions are combinational. They are captured into output registers on a single-cycle `commit` strobe. The result appears for exactly one cycle, and each output value comes with its own write strobe. The surrounding register file performs the actual writes.

Top module: `cp0_ret_gate`

## Requirements
- R1: Op code 1 (exception return) with status bit 2 (error level) set gives `pc_out` = `error_epc` with `pc_we`. It also gives `st_out` = status with bit 2 cleared and every other bit unchanged, with `st_we`.
- R2: Op code 1 with status bit 2 clear gives `pc_out` = `epc`. It also gives `st_out` = status with bit 1 (exception level) cleared and all other bits unchanged, with both write strobes.
- R3: Op code 2 (debug return) while `dbg_mode` is 1 gives `pc_out` = `depc` with `pc_we` and a `dbg_exit` pulse. It writes no status.
- R4: Op code 2 while `dbg_mode` is 0 raises `ri_exc` and nothing else.
- R5: Op code 3 (interrupt disable) returns the old status on `rd_out` with `rd_we`. It writes the status with bit 0 (interrupt enable) cleared.
- R6: Op code 4 (interrupt enable) returns the old status on `rd_out` and writes the status with bit 0 set.
- R7: Op code 5 (hardware read) with `hw_idx` in the range 0 to 3 succeeds when `kernel` is 1 or when `hw_en[hw_idx]` is 1. On success `rd_we` is set and `rd_out` carries the selected value:
  - index 0: `ebase[9:0]` zero-extended;
  - index 1: `sync_step`;
  - index 2: `cyc_count`;
  - index 3: `cyc_res`.
- R8: A hardware read that is not permitted raises `ri_exc` with no `rd_we`, `pc_we` or `st_we`.
- R9: A hardware read with `hw_idx` of 4 or more raises `ri_exc`, even with `kernel` set.
- R10: The outputs are zero after reset. Results appear on the cycle after the `commit` edge, for one cycle. Without `commit`, all strobes stay low.
- R11: Op codes 0, 6 and 7 raise `ri_exc` when committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit | input | 1 | One-cycle strobe that captures the decision |
| op | input | 3 | Operation code |
| hw_idx | input | 5 | Hardware-register index |
| kernel | input | 1 | Core holds coprocessor-0 access |
| dbg_mode | input | 1 | Core is in debug mode |
| status | input | 32 | Current status word |
| epc | input | 32 | Exception return address |
| error_epc | input | 32 | Error return address |
| depc | input | 32 | Debug return address |
| hw_en | input | 4 | Per-register read enable mask |
| ebase | input | 32 | Exception base word |
| sync_step | input | 32 | Cache-sync step size |
| cyc_count | input | 32 | Cycle counter |
| cyc_res | input | 32 | Counter resolution |
| pc_we | output | 1 | PC write strobe |
| pc_out | output | 32 | Next PC |
| st_we | output | 1 | Status write strobe |
| st_out | output | 32 | Next status |
| rd_we | output | 1 | Read-data valid |
| rd_out | output | 32 | Read data |
| ri_exc | output | 1 | Reserved-instruction exception |
| dbg_exit | output | 1 | Debug mode is left |

## Verification
Every result is due exactly one clock after the edge that samples `commit`, and it lasts a single cycle. Each queued expectation therefore carries the cycle number in which it must appear. The monitor compares the outputs at the falling edge of that cycle only. In every other cycle it requires all outputs to be zero, which checks both the one-cycle width and the idle behaviour. Operations are issued back to back, so any result that is late or stretched lands on its neighbour's slot and shows up as a mismatch.

// File: rtl/cp0_ret_gate.sv
module cp0_ret_gate #(
  parameter int XLEN    = 32,
  parameter int NHW     = 4,
  parameter int IDXW    = 5,
  parameter int CPUW    = 10,
  parameter int IE_BIT  = 0,
  parameter int EXL_BIT = 1,
  parameter int ERL_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [2:0]      op,
  input  logic [IDXW-1:0] hw_idx,
  input  logic            kernel,
  input  logic            dbg_mode,
  input  logic [XLEN-1:0] status,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] error_epc,
  input  logic [XLEN-1:0] depc,
  input  logic [NHW-1:0]  hw_en,
  input  logic [XLEN-1:0] ebase,
  input  logic [XLEN-1:0] sync_step,
  input  logic [XLEN-1:0] cyc_count,
  input  logic [XLEN-1:0] cyc_res,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_out,
  output logic            st_we,
  output logic [XLEN-1:0] st_out,
  output logic            rd_we,
  output logic [XLEN-1:0] rd_out,
  output logic            ri_exc,
  output logic            dbg_exit
);
  localparam int SELW = $clog2(NHW);
  localparam logic [2:0] OP_ERET = 3'd1;
  localparam logic [2:0] OP_DRET = 3'd2;
  localparam logic [2:0] OP_DI   = 3'd3;
  localparam logic [2:0] OP_EI   = 3'd4;
  localparam logic [2:0] OP_RDHW = 3'd5;
  localparam logic [XLEN-1:0] IE_M  = XLEN'(1) << IE_BIT;
  localparam logic [XLEN-1:0] EXL_M = XLEN'(1) << EXL_BIT;
  localparam logic [XLEN-1:0] ERL_M = XLEN'(1) << ERL_BIT;

  logic            idx_ok, hw_ok;
  logic [XLEN-1:0] hw_val;
  logic            n_pcw, n_stw, n_rdw, n_ri, n_dx;
  logic [XLEN-1:0] n_pc, n_st, n_rd;

  assign idx_ok = hw_idx < IDXW'(NHW);
  assign hw_ok  = idx_ok && (kernel || hw_en[hw_idx[SELW-1:0]]);

  always_comb begin
    case (hw_idx[SELW-1:0])
      2'd0:    hw_val = XLEN'(ebase[CPUW-1:0]);
      2'd1:    hw_val = sync_step;
      2'd2:    hw_val = cyc_count;
      default: hw_val = cyc_res;
    endcase
  end

  always_comb begin
    n_pcw = 1'b0; n_stw = 1'b0; n_rdw = 1'b0; n_ri = 1'b0; n_dx = 1'b0;
    n_pc  = '0;   n_st  = '0;   n_rd  = '0;
    case (op)
      OP_ERET: begin
        n_pcw = 1'b1;
        n_stw = 1'b1;
        if (status[ERL_BIT]) begin
          n_pc = error_epc;
          n_st = status & ~ERL_M;
        end else begin
          n_pc = epc;
          n_st = status & ~EXL_M;
        end
      end
      OP_DRET: begin
        if (dbg_mode) begin
          n_pcw = 1'b1;
          n_pc  = depc;
          n_dx  = 1'b1;
        end else n_ri = 1'b1;
      end
      OP_DI, OP_EI: begin
        n_rdw = 1'b1;
        n_rd  = status;
        n_stw = 1'b1;
        n_st  = (op == OP_EI) ? (status | IE_M) : (status & ~IE_M);
      end
      OP_RDHW: begin
        if (hw_ok) begin
          n_rdw = 1'b1;
          n_rd  = hw_val;
        end else n_ri = 1'b1;
      end
      default: n_ri = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !commit) begin
      pc_we <= 1'b0; pc_out <= '0;
      st_we <= 1'b0; st_out <= '0;
      rd_we <= 1'b0; rd_out <= '0;
      ri_exc <= 1'b0; dbg_exit <= 1'b0;
    end else begin
      pc_we <= n_pcw; pc_out <= n_pc;
      st_we <= n_stw; st_out <= n_st;
      rd_we <= n_rdw; rd_out <= n_rd;
      ri_exc <= n_ri; dbg_exit <= n_dx;
    end
  end
endmodule

// File: rtl/cp0_ret_gate_chk.sv
module cp0_ret_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit,
  input logic [2:0]  op,
  input logic [4:0]  hw_idx,
  input logic [31:0] status,
  input logic [31:0] epc,
  input logic [31:0] error_epc,
  input logic        pc_we,
  input logic [31:0] pc_out,
  input logic        st_we,
  input logic [31:0] st_out,
  input logic        rd_we,
  input logic [31:0] rd_out,
  input logic        ri_exc,
  input logic        dbg_exit
);
  AST_ERL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == 3'd1 && status[2] |=> pc_we && pc_out == $past(error_epc) && !st_out[2]); // R1
  AST_EXL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == 3'd1 && !status[2] |=> pc_out == $past(epc) && !st_out[1]); // R2
  AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == 3'd4 |=> st_out[0] && rd_out == $past(status)); // R6
  AST_RI_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ri_exc |-> !(pc_we || st_we || rd_we)); // R8
  AST_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == 3'd5 && hw_idx >= 5'd4 |=> ri_exc); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> !(pc_we || st_we || rd_we || ri_exc || dbg_exit)); // R10
endmodule

bind cp0_ret_gate cp0_ret_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .op(op), .hw_idx(hw_idx),
  .status(status), .epc(epc), .error_epc(error_epc),
  .pc_we(pc_we), .pc_out(pc_out), .st_we(st_we), .st_out(st_out),
  .rd_we(rd_we), .rd_out(rd_out), .ri_exc(ri_exc), .dbg_exit(dbg_exit)
);

// File: tb/sim_cp0_ret_gate.sv
module sim_cp0_ret_gate;
  logic clk = 1'b0, rst_n = 1'b0, commit = 1'b0;
  logic [2:0]  op = '0;
  logic [4:0]  hw_idx = '0;
  logic        kernel = 1'b0, dbg_mode = 1'b0;
  logic [31:0] status = '0;
  logic [3:0]  hw_en = '0;
  logic [31:0] epc = 32'h8000_0180, error_epc = 32'hBFC0_0000, depc = 32'h8000_1000;
  logic [31:0] ebase = 32'hABCD_1234, sync_step = 32'd32, cyc_count = 32'h0001_2345, cyc_res = 32'd2;
  logic        pc_we, st_we, rd_we, ri_exc, dbg_exit;
  logic [31:0] pc_out, st_out, rd_out;

  typedef struct packed {
    logic pcw; logic [31:0] pc; logic stw; logic [31:0] st;
    logic rdw; logic [31:0] rd; logic ri; logic dx;
  } res_t;
  typedef struct { res_t r; int due; string tag; } item_t;

  item_t q[$];
  int cyc = 0, tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cp0_ret_gate u0 (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op(op), .hw_idx(hw_idx),
    .kernel(kernel), .dbg_mode(dbg_mode), .status(status), .epc(epc),
    .error_epc(error_epc), .depc(depc), .hw_en(hw_en), .ebase(ebase),
    .sync_step(sync_step), .cyc_count(cyc_count), .cyc_res(cyc_res),
    .pc_we(pc_we), .pc_out(pc_out), .st_we(st_we), .st_out(st_out),
    .rd_we(rd_we), .rd_out(rd_out), .ri_exc(ri_exc), .dbg_exit(dbg_exit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic res_t mk(logic pcw, logic [31:0] pc, logic stw, logic [31:0] st,
                              logic rdw, logic [31:0] rd, logic ri, logic dx);
    res_t t;
    t.pcw = pcw; t.pc = pc; t.stw = stw; t.st = st;
    t.rdw = rdw; t.rd = rd; t.ri = ri; t.dx = dx;
    return t;
  endfunction

  task automatic go(input logic [2:0] o, input logic [4:0] idx, input logic [31:0] st,
                    input logic k, input logic dm, input logic [3:0] en,
                    input res_t e, input string tag);
    item_t it;
    @(posedge clk); #1;
    op = o; hw_idx = idx; status = st; kernel = k; dbg_mode = dm; hw_en = en;
    commit = 1'b1;
    it.r = e; it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    res_t act, exp_r;
    string tag;
    act = mk(pc_we, pc_out, st_we, st_out, rd_we, rd_out, ri_exc, dbg_exit);
    exp_r = '0;
    tag = "R10 idle";
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_r = q[0].r;
      tag = q[0].tag;
      void'(q.pop_front());
    end
    tests++;
    if (act !== exp_r) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp_r);
    end
  end

  always @(posedge clk) if (cyc > 3000 && !done) begin
    done = 1'b1;
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    go(3'd1, 5'd0, 32'h0000_0007, 1'b1, 1'b0, 4'h0, mk(1, 32'hBFC0_0000, 1, 32'h0000_0003, 0, 0, 0, 0), "R1 eret erl");
    go(3'd1, 5'd0, 32'h0000_0013, 1'b1, 1'b0, 4'h0, mk(1, 32'h8000_0180, 1, 32'h0000_0011, 0, 0, 0, 0), "R2 eret exl");
    go(3'd2, 5'd0, 32'h0000_0013, 1'b1, 1'b1, 4'h0, mk(1, 32'h8000_1000, 0, 0, 0, 0, 0, 1), "R3 dret");
    go(3'd2, 5'd0, 32'h0000_0013, 1'b1, 1'b0, 4'h0, mk(0, 0, 0, 0, 0, 0, 1, 0), "R4 dret no dbg");
    go(3'd3, 5'd0, 32'h0000_FF01, 1'b1, 1'b0, 4'h0, mk(0, 0, 1, 32'h0000_FF00, 1, 32'h0000_FF01, 0, 0), "R5 di");
    go(3'd4, 5'd0, 32'h0000_FF00, 1'b1, 1'b0, 4'h0, mk(0, 0, 1, 32'h0000_FF01, 1, 32'h0000_FF00, 0, 0), "R6 ei");
    go(3'd5, 5'd0, 32'h0, 1'b1, 1'b0, 4'h0, mk(0, 0, 0, 0, 1, 32'h0000_0234, 0, 0), "R7 idx0 kernel");
    go(3'd5, 5'd1, 32'h0, 1'b0, 1'b0, 4'b0010, mk(0, 0, 0, 0, 1, 32'd32, 0, 0), "R7 idx1 enabled");
    go(3'd5, 5'd2, 32'h0, 1'b0, 1'b0, 4'b0100, mk(0, 0, 0, 0, 1, 32'h0001_2345, 0, 0), "R7 idx2 enabled");
    go(3'd5, 5'd3, 32'h0, 1'b1, 1'b0, 4'h0, mk(0, 0, 0, 0, 1, 32'd2, 0, 0), "R7 idx3 kernel");
    go(3'd5, 5'd2, 32'h0, 1'b0, 1'b0, 4'b1011, mk(0, 0, 0, 0, 0, 0, 1, 0), "R8 idx2 masked");
    go(3'd5, 5'd0, 32'h0, 1'b0, 1'b0, 4'b0000, mk(0, 0, 0, 0, 0, 0, 1, 0), "R8 idx0 masked");
    go(3'd5, 5'd7, 32'h0, 1'b1, 1'b0, 4'hF, mk(0, 0, 0, 0, 0, 0, 1, 0), "R9 idx7");
    go(3'd5, 5'd4, 32'h0, 1'b1, 1'b0, 4'hF, mk(0, 0, 0, 0, 0, 0, 1, 0), "R9 idx4");
    go(3'd0, 5'd0, 32'h0, 1'b1, 1'b1, 4'hF, mk(0, 0, 0, 0, 0, 0, 1, 0), "R11 op0");
    go(3'd6, 5'd0, 32'h0, 1'b1, 1'b1, 4'hF, mk(0, 0, 0, 0, 0, 0, 1, 0), "R11 op6");
    go(3'd7, 5'd0, 32'h0, 1'b1, 1'b1, 4'hF, mk(0, 0, 0, 0, 0, 0, 1, 0), "R11 op7");
    @(posedge clk); #1 commit = 1'b0;
    op = 3'd1; status = 32'h0000_0007;
    repeat (4) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R10 pending results: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule